// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the data-register side of a boundary-scan test path for a bank of I/O pads. Every pad owns a fixed group of three scan cells: one for the output-enable, one for the output value and one for the pad input. Each cell has a capture/shift flop, an update stage and two multiplexers. The first multiplexer picks the flop's next value from the serial path or from captured data. The second picks what leaves the cell: the functional value, or the value held in the update stage. All groups are joined into one serial register between `tdi` and `tdo`.

A TAP controller outside this block supplies the capture, shift and update strobes and the test-mode select. All of them are sampled on the rising edge of `tck`. The strobes are decoded into one operation per edge. `OP_CAPTURE` is chosen when `capture_dr` is high. `OP_SHIFT` is chosen when `shift_dr` is high and `capture_dr` is low. `OP_HOLD` is chosen otherwise. Any operation can follow any other on the next edge. The update stage has its own load enable, `update_dr`, which is independent of this decode.

Bit k of the register is numbered from the `tdo` end (bit 0) toward `tdi` (bit 3N-1). Pad p holds bit 3p+2 (enable), bit 3p+1 (output) and bit 3p (input). Seen from `tdi`, the cells of each group therefore come in the order enable, output, input.

Top module: `bsr_chain`

## Requirements
- R1: While `trst_n` is low, and after it is released, every capture/shift flop and every update stage holds 0, so in test mode `pad_oe`, `pad_out` and `core_in` are all 0.
- R2: The register is exactly 3×NUM_PADS bits long. A 1 shifted in at `tdi` after a register full of zeros first shows on `tdo` after exactly 3×NUM_PADS shift edges, counting the edge that took it in.
- R3: On an edge with `capture_dr` high, bit 3p+2 takes `core_oe[p]`, bit 3p+1 takes `core_out[p]` and bit 3p takes `pad_in[p]`.
- R4: When `capture_dr` and `shift_dr` are both high on an edge, the capture is performed and the shift is not.
- R5: The update stages load all 3×NUM_PADS bits from the capture/shift flops on an edge with `update_dr` high. On every other edge they keep their value, including edges that shift or capture.
- R6: On an edge with both `update_dr` and `shift_dr` high, the update stages take the register contents from before that edge's shift.
- R7: With `test_mode` low, `pad_oe`, `pad_out` and `core_in` equal `core_oe`, `core_out` and `pad_in` respectively, combinationally.
- R8: With `test_mode` high, `pad_oe[p]`, `pad_out[p]` and `core_in[p]` show update bits 3p+2, 3p+1 and 3p respectively.
- R9: `tdo` shows register bit 0 while `shift_dr` is high and is 0 while `shift_dr` is low.
- R10: On an edge with no capture and no shift, the register contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset of all scan state |
| tdi | input | 1 | Serial data into bit 3N-1 |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update-stage load strobe |
| test_mode | input | 1 | Selects update-stage values onto the pad and core sides |
| core_oe | input | NUM_PADS | Functional output-enable from the core |
| core_out | input | NUM_PADS | Functional output value from the core |
| pad_in | input | NUM_PADS | Value received at each pad |
| pad_oe | output | NUM_PADS | Output-enable driven to each pad |
| pad_out | output | NUM_PADS | Output value driven to each pad |
| core_in | output | NUM_PADS | Input value presented to the core |
| tdo | output | 1 | Serial data out from bit 0 |

## Verification
Two functions can fall on the same edge: the serial shift of the register and the load of the update stages. The bench provokes this by first shifting a known word in fully, then applying one edge with `shift_dr` and `update_dr` both high. It judges the result at the pads in test mode, where the pads must show the word as it stood before that edge and not the word moved by one place. The second overlap is capture together with shift. It is judged by shifting the register out afterwards and comparing it with the captured pad and core values.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int CELLS_PER_PAD = 3;
    localparam int SLOT_IN       = 0;
    localparam int SLOT_OUT      = 1;
    localparam int SLOT_EN       = 2;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } bsr_op_e;

endpackage

// File: rtl/bsr_op_decode.sv
module bsr_op_decode
    import bsr_pkg::*;
(
    input  logic    capture_dr,
    input  logic    shift_dr,
    output bsr_op_e op
);

    // Capture outranks shift (R4).
    always_comb begin
        unique case ({capture_dr, shift_dr})
            2'b10, 2'b11: op = OP_CAPTURE;
            2'b01:        op = OP_SHIFT;
            default:      op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  bsr_op_e op,
    input  logic    update_en,
    input  logic    scan_in,
    input  logic    capture_val,
    input  logic    func_val,
    input  logic    test_mode,
    output logic    scan_q,
    output logic    upd_q,
    output logic    drive_val
);

    logic scan_d;

    // First mux: serial path or captured value.
    always_comb begin
        unique case (op)
            OP_CAPTURE: scan_d = capture_val;
            OP_SHIFT:   scan_d = scan_in;
            default:    scan_d = scan_q;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            scan_q <= 1'b0;
        end else begin
            scan_q <= scan_d;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_q <= 1'b0;
        end else if (update_en) begin
            upd_q <= scan_q;
        end
    end

    // Second mux: functional value or held test value.
    assign drive_val = test_mode ? upd_q : func_val;

    p_hold_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_HOLD) |=> $stable(scan_q));

    p_upd_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
        !update_en |=> $stable(upd_q));

endmodule

// File: rtl/bsr_pad_group.sv
module bsr_pad_group
    import bsr_pkg::*;
(
    input  logic                     tck,
    input  logic                     trst_n,
    input  bsr_op_e                  op,
    input  logic                     update_en,
    input  logic                     test_mode,
    input  logic                     scan_in,
    input  logic                     core_oe,
    input  logic                     core_out,
    input  logic                     pad_in,
    output logic                     pad_oe,
    output logic                     pad_out,
    output logic                     core_in,
    output logic [CELLS_PER_PAD-1:0] scan_bits,
    output logic [CELLS_PER_PAD-1:0] upd_bits
);

    logic [CELLS_PER_PAD-1:0] func_vec;
    logic [CELLS_PER_PAD-1:0] drive_vec;

    assign func_vec[SLOT_EN]  = core_oe;
    assign func_vec[SLOT_OUT] = core_out;
    assign func_vec[SLOT_IN]  = pad_in;

    assign pad_oe  = drive_vec[SLOT_EN];
    assign pad_out = drive_vec[SLOT_OUT];
    assign core_in = drive_vec[SLOT_IN];

    for (genvar k = 0; k < CELLS_PER_PAD; k++) begin : g_cell
        logic serial_src;
        if (k == CELLS_PER_PAD - 1) begin : g_head
            assign serial_src = scan_in;
        end else begin : g_body
            assign serial_src = scan_bits[k+1];
        end

        bsr_cell u_cell (
            .tck         (tck),
            .trst_n      (trst_n),
            .op          (op),
            .update_en   (update_en),
            .scan_in     (serial_src),
            .capture_val (func_vec[k]),
            .func_val    (func_vec[k]),
            .test_mode   (test_mode),
            .scan_q      (scan_bits[k]),
            .upd_q       (upd_bits[k]),
            .drive_val   (drive_vec[k])
        );
    end

    p_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_CAPTURE) |=> (scan_bits == $past({core_oe, core_out, pad_in})));

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NUM_PADS = 8
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tdi,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                test_mode,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] core_in,
    output logic                tdo
);

    localparam int CHAIN_LEN = CELLS_PER_PAD * NUM_PADS;

    bsr_op_e              op;
    logic [CHAIN_LEN-1:0] scan_all;
    logic [CHAIN_LEN-1:0] upd_all;

    bsr_op_decode u_decode (
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .op         (op)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        logic group_in;
        if (p == NUM_PADS - 1) begin : g_first
            assign group_in = tdi;
        end else begin : g_next
            assign group_in = scan_all[CELLS_PER_PAD*(p+1)];
        end

        bsr_pad_group u_group (
            .tck       (tck),
            .trst_n    (trst_n),
            .op        (op),
            .update_en (update_dr),
            .test_mode (test_mode),
            .scan_in   (group_in),
            .core_oe   (core_oe[p]),
            .core_out  (core_out[p]),
            .pad_in    (pad_in[p]),
            .pad_oe    (pad_oe[p]),
            .pad_out   (pad_out[p]),
            .core_in   (core_in[p]),
            .scan_bits (scan_all[CELLS_PER_PAD*p +: CELLS_PER_PAD]),
            .upd_bits  (upd_all[CELLS_PER_PAD*p +: CELLS_PER_PAD])
        );
    end

    // Output mux toward the serial port.
    assign tdo = shift_dr ? scan_all[0] : 1'b0;

    p_shift_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !capture_dr) |=>
            (scan_all == {$past(tdi), $past(scan_all[CHAIN_LEN-1:1])}));

    p_update_r6: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr |=> (upd_all == $past(scan_all)));

    p_priority_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (capture_dr && shift_dr) |=> (scan_all[0] == $past(pad_in[0])));

    p_reset_r1: assert property (@(posedge tck)
        !trst_n |-> (scan_all == '0 && upd_all == '0));

endmodule

// File: tb/bsr_chain_bench.sv
module bsr_chain_bench;

    localparam int NP = 4;
    localparam int L  = 3 * NP;

    logic          tck = 1'b0;
    logic          trst_n;
    logic          tdi, capture_dr, shift_dr, update_dr, test_mode;
    logic [NP-1:0] core_oe, core_out, pad_in;
    logic [NP-1:0] pad_oe, pad_out, core_in;
    logic          tdo;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #2.5 tck = ~tck;

    bsr_chain #(.NUM_PADS(NP)) u_bsr_chain (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .test_mode(test_mode), .core_oe(core_oe), .core_out(core_out),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .core_in(core_in), .tdo(tdo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [L-1:0] cap_word(input logic [NP-1:0] oe,
                                              input logic [NP-1:0] o,
                                              input logic [NP-1:0] i);
        logic [L-1:0] w;
        for (int p = 0; p < NP; p++) begin
            w[3*p+2] = oe[p];
            w[3*p+1] = o[p];
            w[3*p]   = i[p];
        end
        return w;
    endfunction

    task automatic check_pads(input string req, input logic [L-1:0] w);
        logic [NP-1:0] eo, eout, ein;
        for (int p = 0; p < NP; p++) begin
            eo[p]   = w[3*p+2];
            eout[p] = w[3*p+1];
            ein[p]  = w[3*p];
        end
        #1;
        check(req, {pad_oe, pad_out, core_in}, {eo, eout, ein});
    endtask

    task automatic shift_word(input logic [L-1:0] vin, output logic [L-1:0] vout);
        for (int i = 0; i < L; i++) begin
            @(negedge tck);
            shift_dr = 1'b1;
            tdi      = vin[i];
            #1 vout[i] = tdo;
        end
        @(negedge tck);
        shift_dr = 1'b0;
        tdi      = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge tck); update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [L-1:0] got, w, w2;
        int cnt;
        trst_n = 1'b0; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
        test_mode = 1'b1; core_oe = '1; core_out = '1; pad_in = '1;
        repeat (3) @(negedge tck);
        check_pads("R1 reset pads", '0);
        check("R9 tdo idle", tdo, 0);
        trst_n = 1'b1;
        @(negedge tck);
        check_pads("R1 after release", '0);

        // R7: functional pass-through sweep
        test_mode = 1'b0;
        for (int v = 0; v < 256; v++) begin
            core_oe = v[3:0]; core_out = v[7:4]; pad_in = ~v[3:0];
            #1;
            check("R7 passthrough", {pad_oe, pad_out, core_in},
                  {v[3:0], v[7:4], ~v[3:0]});
        end

        // R3: capture sweep, then shift out
        for (int c = 0; c < 16; c++) begin
            @(negedge tck);
            core_oe = c[3:0]; core_out = c[3:0] ^ 4'h5; pad_in = ~c[3:0];
            capture_dr = 1'b1;
            @(negedge tck);
            capture_dr = 1'b0;
            shift_word('0, got);
            check("R3 capture order", got, cap_word(c[3:0], c[3:0] ^ 4'h5, ~c[3:0]));
        end

        // R4: capture together with shift
        @(negedge tck);
        core_oe = 4'hA; core_out = 4'h3; pad_in = 4'h6;
        capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
        shift_word('0, got);
        check("R4 capture priority", got, cap_word(4'hA, 4'h3, 4'h6));

        // R2: chain length
        shift_word('0, got);
        @(negedge tck);
        shift_dr = 1'b1; tdi = 1'b1;
        cnt = 0;
        for (int i = 0; i < 2 * L; i++) begin
            @(negedge tck);
            tdi = 1'b0;
            cnt++;
            #1;
            if (tdo === 1'b1) break;
        end
        check("R2 chain length", cnt, L);
        @(negedge tck); shift_dr = 1'b0;
        #1 check("R9 tdo low when not shifting", tdo, 0);

        // R5 / R8: update sweep
        test_mode = 1'b1;
        for (int k = 0; k < 12; k++) begin
            pulse_update();
            w2 = '0;
            shift_word('0, got);
            pulse_update();
            check_pads("R8 cleared", '0);
            w = L'(k * 12'h2B7 + 12'h0C3);
            shift_word(w, got);
            check_pads("R5 hold during shift", '0);
            pulse_update();
            check_pads("R8 test drive", w);
            @(negedge tck); capture_dr = 1'b1;
            @(negedge tck); capture_dr = 1'b0;
            check_pads("R5 hold during capture", w);
        end

        // R6: update and shift on one edge
        w  = 12'hC35;
        w2 = 12'h5A9;
        shift_word(w, got);
        pulse_update();
        check_pads("R6 setup", w);
        shift_word(w2, got);
        @(negedge tck);
        shift_dr = 1'b1; update_dr = 1'b1; tdi = 1'b1;
        @(negedge tck);
        shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        check_pads("R6 pre-shift contents", w2);
        shift_word('0, got);
        check("R6 shift still applied", got, {1'b1, w2[L-1:1]});

        // R10: idle edges keep contents
        w = 12'h9E4;
        shift_word(w, got);
        repeat (6) @(negedge tck);
        shift_word('0, got);
        check("R10 hold on idle", got, w);

        finish_run();
    end

endmodule